// File: doc/BRIEF.md
# Event Interval Recorder

The block watches four timing signals and writes one 16-bit word to an external word-addressed memory each time one of them acts. The four signals are a trigger pulse, an event-counter reset pulse, a bunch-counter reset pulse and a busy level. Each word carries a 4-bit tag and a 12-bit period. The tag shows which signals acted in that clock. The period is the number of clocks since the previous word, and it saturates rather than wraps. A host reads the pointer to the next free location and the count of words written, and can clear both with a single command.

A test mode replaces the period log with a running 32-bit trigger count. Each trigger then writes two consecutive words, low half first. All inputs are synchronous to the block clock. The event inputs count once for every clock in which they are high.

Top module: `interval_recorder`

## Requirements
- R1: When `sinkEn` is high and `testMode` is low, a word is written in each clock where `trigIn`, `ecrIn` or `bcrIn` is high, or where `busyIn` differs from its value in the previous clock. Several such events in one clock give one word.
- R2: Word layout: bit 15 holds the `busyIn` level in the event clock, bit 14 `ecrIn`, bit 13 `bcrIn`, bit 12 `trigIn`.
- R3: Bits 11:0 hold the number of clocks since the previous word in which no word was written. The count starts from the last enable, clear or reset. Back-to-back events give 0, a count of 4094 is stored exactly, and any longer count is stored as 0xFFF.
- R4: `nextAddr` always equals the address the next word will use. It rises by one per word and wraps to 0 after 2^ADDR_W-1.
- R5: `eventCount` equals the number of words written since the last clear or reset.
- R6: A high `addrClr` sets the pointer, the word count, the period count and the trigger count to zero. It wins over everything in the same clock: events in that clock are not recorded, and a pending high half is dropped.
- R7: While `sinkEn` is low, nothing is written and the period count stays at zero. The busy history is still tracked, so enabling while busy is high writes no word.
- R8: With `sinkEn` and `testMode` high, a trigger adds one to a 32-bit trigger count and writes bits 15:0 of the new count. In the following clock, bits 31:16 are written to the next address. Other events are not recorded, and a trigger in that second clock is ignored.
- R9: `memWe`, `memAddr` and `memData` change one clock after the input clock that causes them. `memWe` is high for exactly one clock per word.
- R10: After reset, `memWe`, `memAddr`, `memData`, `nextAddr` and `eventCount` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sinkEn | input | 1 | Recording enable |
| testMode | input | 1 | Log the trigger count instead of periods |
| addrClr | input | 1 | Clear pointer and counts |
| trigIn | input | 1 | Trigger event |
| ecrIn | input | 1 | Event-counter reset event |
| bcrIn | input | 1 | Bunch-counter reset event |
| busyIn | input | 1 | Busy level |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | 16 | Memory write data |
| memWe | output | 1 | Memory write enable |
| nextAddr | output | ADDR_W | Address of the next word |
| eventCount | output | CNT_W | Words written since the last clear |

## Verification
The bench builds the block with ADDR_W = 4. With only sixteen locations, a few dozen events carry the pointer across its wrap point several times. CNT_W stays at 32, and the 12-bit period field is fixed by the word layout. Idle runs of 4094, 4095 and 5000 clocks therefore reach the exact-limit and saturated codes directly. Test mode is exercised with triggers arriving inside the pending second write, and with a clear landing on that second write.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int WORD_W   = 16;
  localparam int PERIOD_W = 12;
  localparam int TRIG_W   = 32;

  typedef struct packed {
    logic       clearAll;
    logic       writeEvent;
    logic       writeLo;
    logic       writeHi;
    logic       sinkOn;
    logic [3:0] tags;
  } recStrobes_t;
endpackage

// File: rtl/rec_ctrl.sv
module rec_ctrl
  import rec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sinkEn,
  input  logic        testMode,
  input  logic        addrClr,
  input  logic        trigIn,
  input  logic        ecrIn,
  input  logic        bcrIn,
  input  logic        busyIn,
  output recStrobes_t strb
);
  logic busyQ;
  logic hiPending;
  logic busyEdge;
  logic anyEvent;

  assign busyEdge = busyIn ^ busyQ;
  assign anyEvent = trigIn | ecrIn | bcrIn | busyEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      hiPending <= 1'b0;
    end else begin
      busyQ     <= busyIn;
      hiPending <= strb.writeLo;
    end
  end

  always_comb begin
    strb        = '0;
    strb.sinkOn = sinkEn;
    strb.tags   = {busyIn, ecrIn, bcrIn, trigIn};
    if (addrClr)                strb.clearAll   = 1'b1;
    else if (hiPending)         strb.writeHi    = 1'b1;
    else if (sinkEn && testMode) strb.writeLo   = trigIn;
    else if (sinkEn)            strb.writeEvent = anyEvent;
  end

  // R6, R8: at most one action per clock
  assert_single_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clearAll, strb.writeEvent, strb.writeLo, strb.writeHi}));

  // R8: the high half follows the low half unless a clear intervenes
  assert_hi_follows_lo_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeLo |=> (addrClr || strb.writeHi));

  // R7: no new record starts while recording is disabled
  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!sinkEn) |-> !(strb.writeEvent || strb.writeLo));
endmodule

// File: rtl/rec_datapath.sv
module rec_datapath
  import rec_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  recStrobes_t       strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData,
  output logic              memWe,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [CNT_W-1:0]  eventCount
);
  localparam logic [PERIOD_W-1:0] PERIOD_MAX = {PERIOD_W{1'b1}};

  logic [PERIOD_W-1:0] periodCnt;
  logic [TRIG_W-1:0]   trigCnt;
  logic [TRIG_W-1:0]   trigNext;
  logic                anyWrite;

  assign trigNext = trigCnt + 1'b1;
  assign anyWrite = strb.writeEvent | strb.writeLo | strb.writeHi;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll || !strb.sinkOn || strb.writeEvent)
      periodCnt <= '0;
    else if (periodCnt != PERIOD_MAX)
      periodCnt <= periodCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      trigCnt    <= '0;
      nextAddr   <= '0;
      eventCount <= '0;
    end else begin
      if (strb.writeLo) trigCnt <= trigNext;
      if (anyWrite) begin
        nextAddr   <= nextAddr + 1'b1;
        eventCount <= eventCount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= anyWrite;
      if (anyWrite) memAddr <= nextAddr;
      if (strb.writeEvent)   memData <= {strb.tags, periodCnt};
      else if (strb.writeLo) memData <= trigNext[WORD_W-1:0];
      else if (strb.writeHi) memData <= trigCnt[TRIG_W-1:WORD_W];
    end
  end

  // R3: a saturated period is stored as the all-ones code
  assert_period_saturates_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeEvent && periodCnt == PERIOD_MAX) |=> memData[PERIOD_W-1:0] == PERIOD_MAX);

  // R4: after each word the pointer sits one past the written address
  assert_pointer_advances_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> nextAddr == ADDR_W'(memAddr + 1'b1));

  // R6: clear empties pointer and count and writes nothing
  assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (nextAddr == '0 && eventCount == '0 && !memWe));
endmodule

// File: rtl/interval_recorder.sv
module interval_recorder
  import rec_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sinkEn,
  input  logic              testMode,
  input  logic              addrClr,
  input  logic              trigIn,
  input  logic              ecrIn,
  input  logic              bcrIn,
  input  logic              busyIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic              memWe,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [CNT_W-1:0]  eventCount
);
  recStrobes_t strb;

  rec_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sinkEn(sinkEn), .testMode(testMode),
    .addrClr(addrClr), .trigIn(trigIn), .ecrIn(ecrIn), .bcrIn(bcrIn),
    .busyIn(busyIn), .strb(strb)
  );

  rec_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .memAddr(memAddr),
    .memData(memData), .memWe(memWe), .nextAddr(nextAddr),
    .eventCount(eventCount)
  );
endmodule

// File: tb/interval_recorder_tb.sv
module interval_recorder_tb_top;
  localparam int AW = 4;
  localparam int CW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, sinkEn = 1'b0, testMode = 1'b0, addrClr = 1'b0;
  logic trigIn = 1'b0, ecrIn = 1'b0, bcrIn = 1'b0, busyIn = 1'b0;
  logic [AW-1:0] memAddr, nextAddr;
  logic [15:0]   memData;
  logic          memWe;
  logic [CW-1:0] eventCount;

  interval_recorder #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .sinkEn(sinkEn), .testMode(testMode),
    .addrClr(addrClr), .trigIn(trigIn), .ecrIn(ecrIn), .bcrIn(bcrIn),
    .busyIn(busyIn), .memAddr(memAddr), .memData(memData), .memWe(memWe),
    .nextAddr(nextAddr), .eventCount(eventCount)
  );

  int checks = 0;
  int fails  = 0;

  // reference state
  int mPtr = 0, mCnt = 0, mPer = 0, mAddr = 0, mData = 0;
  bit mPend = 0, mBusy = 0, mWe = 0;
  longint mTrig = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic periodTick();
    if (sinkEn) mPer = (mPer < 4095) ? mPer + 1 : 4095;
    else mPer = 0;
  endtask

  task automatic advance();
    mPtr = (mPtr + 1) % (1 << AW);
    mCnt++;
  endtask

  task automatic step(string req);
    bit evt;
    evt = trigIn | ecrIn | bcrIn | (busyIn != mBusy);
    mWe = 0;
    if (addrClr) begin
      mPtr = 0; mCnt = 0; mPer = 0; mTrig = 0; mPend = 0;
    end else if (mPend) begin
      mWe = 1; mAddr = mPtr; mData = int'((mTrig >> 16) & 16'hffff);
      mPend = 0; advance(); periodTick();
    end else if (sinkEn && testMode && trigIn) begin
      mTrig = (mTrig + 1) & 64'hffff_ffff;
      mWe = 1; mAddr = mPtr; mData = int'(mTrig & 16'hffff);
      mPend = 1; advance(); periodTick();
    end else if (sinkEn && !testMode && evt) begin
      mWe = 1; mAddr = mPtr;
      mData = (int'(busyIn) << 15) | (int'(ecrIn) << 14) | (int'(bcrIn) << 13)
            | (int'(trigIn) << 12) | mPer;
      advance(); mPer = 0;
    end else begin
      periodTick();
    end
    mBusy = busyIn;
    @(posedge clk);
    @(negedge clk);
    check(memWe == mWe, req, "memWe", memWe, mWe);
    if (mWe) begin
      check(memAddr == AW'(mAddr), req, "memAddr", memAddr, mAddr);
      check(memData == 16'(mData), req, "memData", memData, mData);
    end
    check(nextAddr == AW'(mPtr), req, "nextAddr", nextAddr, mPtr);
    check(eventCount == CW'(mCnt), req, "eventCount", eventCount, mCnt);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic ev(bit t, bit e, bit b, string req);
    trigIn = t; ecrIn = e; bcrIn = b;
    step(req);
    trigIn = 0; ecrIn = 0; bcrIn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(memWe == 0, "R10", "memWe", memWe, 0);
    check(memAddr == 0, "R10", "memAddr", memAddr, 0);
    check(memData == 0, "R10", "memData", memData, 0);
    check(nextAddr == 0, "R10", "nextAddr", nextAddr, 0);
    check(eventCount == 0, "R10", "eventCount", eventCount, 0);
    rstN = 1'b1;

    sinkEn = 1;
    idle(3, "R1");
    ev(1, 0, 0, "R1");
    idle(2, "R3");
    ev(1, 0, 0, "R3");
    ev(1, 0, 0, "R3");           // back-to-back: period 0
    ev(0, 1, 1, "R2");           // merged tags
    busyIn = 1; step("R2");      // rising busy, bit 15 set
    idle(2, "R2");
    busyIn = 0; step("R2");      // falling busy, bit 15 clear
    ev(1, 0, 0, "R9");

    sinkEn = 0;
    ev(1, 1, 1, "R7");
    busyIn = 1; step("R7");
    idle(2, "R7");
    sinkEn = 1;
    idle(3, "R7");               // busy already high: no word
    busyIn = 0; step("R7");

    for (int i = 0; i < 20; i++) ev(i % 3 == 0, i % 3 == 1, i % 3 == 2, "R4");
    for (int i = 0; i < 4; i++) begin ev(1, 0, 0, "R5"); idle(1, "R5"); end

    addrClr = 1; trigIn = 1; step("R6");
    addrClr = 0; trigIn = 0;
    idle(4094, "R3");
    ev(1, 0, 0, "R3");           // 0xFFE exact
    idle(4095, "R3");
    ev(1, 0, 0, "R3");           // 0xFFF
    idle(5000, "R3");
    ev(0, 1, 0, "R3");

    testMode = 1;
    idle(2, "R8");
    ev(1, 0, 0, "R8");
    ev(1, 0, 0, "R8");           // trigger during high half: ignored
    ev(0, 1, 1, "R8");
    busyIn = 1; step("R8");
    busyIn = 0; step("R8");
    for (int i = 0; i < 6; i++) begin ev(1, 0, 0, "R8"); idle(i % 2, "R8"); end
    ev(1, 0, 0, "R6");
    addrClr = 1; step("R6");     // clear drops pending high half
    addrClr = 0;
    idle(2, "R6");
    ev(1, 0, 0, "R6");
    idle(3, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule